// File: doc/BRIEF.md
# Bidirectional-Port Universal Shift Register

This block is a storage and shift register, eight bits wide by default, with four
operations: keep the current contents, move them one place towards the high end,
move them one place towards the low end, or capture a word from the parallel port.
The parallel port serves both ways. The block captures from it during a load and
drives its contents onto it at other times. The port is split into an input
vector, an output vector and one drive-enable, so that the surrounding logic or a
bench can build the tri-state bus from them.

The port is driven only when both active-low enables are low and the register is
not loading. Two serial taps show the lowest and highest bits at all times,
whatever the enables are doing, so several instances can be chained into a longer
shift path. An active-low reset clears the register at once, without waiting for
a clock edge.

Top module: `bidir_shift_reg`

## Requirements
- R1: While `rst_n` is low the register is all zeros at once, with no clock edge needed, and this overrides every mode.
- R2: With `mode` = 2'b00, a rising edge leaves the register unchanged, for any number of edges.
- R3: With `mode` = 2'b10, a rising edge moves bit n into bit n+1 and puts `ser_up_in` into bit 0.
- R4: With `mode` = 2'b01, a rising edge moves bit n into bit n-1 and puts `ser_dn_in` into the top bit.
- R5: With `mode` = 2'b11, a rising edge copies `pin_in` bit for bit into the register.
- R6: `pin_oe` is 1 only when `en_a_n` and `en_b_n` are both 0 and `mode` is not 2'b11. Otherwise it is 0.
- R7: `pin_out` always equals the register contents, with bit n on `pin_out[n]`.
- R8: `tap_lo` always equals bit 0 and `tap_hi` always equals the top bit, whatever the enables are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all operations take place on its rising edge |
| rst_n | input | 1 | Asynchronous clear, active low |
| mode | input | 2 | 00 keep, 10 shift towards the top bit, 01 shift towards bit 0, 11 load |
| ser_up_in | input | 1 | Serial bit that enters bit 0 when shifting up |
| ser_dn_in | input | 1 | Serial bit that enters the top bit when shifting down |
| en_a_n | input | 1 | First port drive enable, active low |
| en_b_n | input | 1 | Second port drive enable, active low |
| pin_in | input | WIDTH | Value seen on the shared parallel port |
| pin_out | output | WIDTH | Value the block puts on the shared port |
| pin_oe | output | 1 | High when the block drives the shared port |
| tap_lo | output | 1 | Serial output showing bit 0 |
| tap_hi | output | 1 | Serial output showing the top bit |

## Verification
The bench drives a reset pulse in the middle of a clock cycle and checks that the
outputs are zero before the next edge. A reset built on the clock would keep the
old contents until that edge. It shifts a known word fully out in each direction.
This catches a swapped direction, a shift that drops or duplicates a serial bit,
and an encoding in which the two shift codes are exchanged. It walks through all
four combinations of the two enables in every mode, including a load with both
enables low, where a design that drives the port during a load would fight the
external data. The taps are checked while the enables are high, since a design
that gated them would go quiet there.

// File: rtl/bidir_shift_reg.sv
module bidir_shift_reg #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       mode,
  input  logic             ser_up_in,
  input  logic             ser_dn_in,
  input  logic             en_a_n,
  input  logic             en_b_n,
  input  logic [WIDTH-1:0] pin_in,
  output logic [WIDTH-1:0] pin_out,
  output logic             pin_oe,
  output logic             tap_lo,
  output logic             tap_hi
);
  localparam int MSB = WIDTH - 1;
  localparam logic [1:0] M_KEEP = 2'b00;
  localparam logic [1:0] M_DOWN = 2'b01;
  localparam logic [1:0] M_UP   = 2'b10;
  localparam logic [1:0] M_LOAD = 2'b11;

  logic [MSB:0] q;
  logic [MSB:0] q_nxt;

  always_comb begin
    case (mode)
      M_UP:    q_nxt = {q[MSB-1:0], ser_up_in};
      M_DOWN:  q_nxt = {ser_dn_in, q[MSB:1]};
      M_LOAD:  q_nxt = pin_in;
      default: q_nxt = q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= q_nxt;
  end

  assign pin_out = q;
  assign pin_oe  = !en_a_n && !en_b_n && (mode != M_LOAD);
  assign tap_lo  = q[0];
  assign tap_hi  = q[MSB];

  p_clear_r1: assert property (@(posedge clk) !rst_n |-> (pin_out == '0));

  p_keep_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == M_KEEP) |=> $stable(pin_out));

  p_up_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == M_UP) |=> (pin_out == {$past(pin_out[MSB-1:0]), $past(ser_up_in)}));

  p_down_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == M_DOWN) |=> (pin_out == {$past(ser_dn_in), $past(pin_out[MSB:1])}));

  p_load_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == M_LOAD) |=> (pin_out == $past(pin_in)));

  p_no_contend_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == M_LOAD || en_a_n || en_b_n) |-> !pin_oe);

  p_taps_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (tap_lo == pin_out[0]) && (tap_hi == pin_out[MSB]));
endmodule

// File: tb/bidir_shift_reg_bench.sv
module bidir_shift_reg_bench;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [1:0]   mode = 2'b00;
  logic         ser_up_in = 1'b0;
  logic         ser_dn_in = 1'b0;
  logic         en_a_n = 1'b1;
  logic         en_b_n = 1'b1;
  logic [W-1:0] pin_in = '0;
  logic [W-1:0] pin_out;
  logic         pin_oe;
  logic         tap_lo;
  logic         tap_hi;

  int checks = 0;
  int errors = 0;
  bit model [W];

  always #2 clk = ~clk;

  bidir_shift_reg #(.WIDTH(W)) u_bidir_shift_reg (
    .clk(clk), .rst_n(rst_n), .mode(mode), .ser_up_in(ser_up_in),
    .ser_dn_in(ser_dn_in), .en_a_n(en_a_n), .en_b_n(en_b_n), .pin_in(pin_in),
    .pin_out(pin_out), .pin_oe(pin_oe), .tap_lo(tap_lo), .tap_hi(tap_hi)
  );

  function automatic logic [W-1:0] model_word();
    logic [W-1:0] v;
    for (int i = 0; i < W; i++) v[i] = model[i];
    return v;
  endfunction

  task automatic check(string req, logic [W-1:0] act, logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic compare_all(string req);
    bit oe_exp;
    oe_exp = (en_a_n == 1'b0) && (en_b_n == 1'b0) && (mode != 2'b11);
    check(req, pin_out, model_word());
    check("R7", pin_out, model_word());
    check("R6", {{(W-1){1'b0}}, pin_oe}, {{(W-1){1'b0}}, oe_exp});
    check("R8", {{(W-2){1'b0}}, tap_hi, tap_lo}, {{(W-2){1'b0}}, model[W-1], model[0]});
  endtask

  task automatic step(string req);
    bit nxt [W];
    @(posedge clk);
    case (mode)
      2'b10: begin
        nxt[0] = ser_up_in;
        for (int i = 1; i < W; i++) nxt[i] = model[i-1];
      end
      2'b01: begin
        nxt[W-1] = ser_dn_in;
        for (int i = 0; i < W-1; i++) nxt[i] = model[i+1];
      end
      2'b11: for (int i = 0; i < W; i++) nxt[i] = pin_in[i];
      default: for (int i = 0; i < W; i++) nxt[i] = model[i];
    endcase
    model = nxt;
    @(negedge clk);
    compare_all(req);
  endtask

  task automatic clear_model();
    for (int i = 0; i < W; i++) model[i] = 1'b0;
  endtask

  string tag;

  initial begin
    clear_model();
    #1;
    compare_all("R1");
    repeat (2) @(negedge clk);
    compare_all("R1");
    rst_n = 1'b1;
    mode = 2'b00;
    step("R2");

    en_a_n = 1'b0; en_b_n = 1'b0;
    mode = 2'b11; pin_in = 8'hA5;
    #1 compare_all("R6");
    step("R5");
    mode = 2'b00;
    repeat (4) step("R2");

    mode = 2'b10;
    for (int i = 0; i < W; i++) begin
      ser_up_in = i[0];
      step("R3");
    end
    mode = 2'b11; pin_in = 8'h81; step("R5");
    mode = 2'b01;
    for (int i = 0; i < W; i++) begin
      ser_dn_in = ~i[1];
      step("R4");
    end

    for (int m = 0; m < 4; m++)
      for (int e = 0; e < 4; e++) begin
        mode = m[1:0];
        en_a_n = e[0]; en_b_n = e[1];
        pin_in = 8'h3C ^ 8'(m * 17 + e);
        ser_up_in = e[0]; ser_dn_in = ~e[1];
        step(m == 0 ? "R2" : m == 1 ? "R4" : m == 2 ? "R3" : "R5");
      end

    en_a_n = 1'b1; en_b_n = 1'b1;
    mode = 2'b11; pin_in = 8'h81; step("R8");
    mode = 2'b00; step("R8");

    for (int n = 0; n < 400; n++) begin
      mode = 2'($urandom);
      en_a_n = 1'($urandom); en_b_n = 1'($urandom);
      ser_up_in = 1'($urandom); ser_dn_in = 1'($urandom);
      pin_in = 8'($urandom);
      tag = mode == 0 ? "R2" : mode == 1 ? "R4" : mode == 2 ? "R3" : "R5";
      step(tag);
    end

    mode = 2'b11; pin_in = 8'hFF; step("R5");
    mode = 2'b10;
    #0.5 rst_n = 1'b0;
    clear_model();
    #0.5 compare_all("R1");
    @(posedge clk);
    @(negedge clk);
    compare_all("R1");
    rst_n = 1'b1;
    mode = 2'b00;
    step("R2");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(4 * 200000);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule